// File: doc/BRIEF.md
# I2C Target Read Engine with CRC

This block is an I2C target that answers register reads from a controller. The controller first addresses the target for a write and sends one register address byte, which the target keeps as its read pointer. The controller then addresses the target again for a read. It can do this with a repeated start, or after a stop and a fresh start. The target returns the register contents, one byte per ninth-clock handshake. The pointer steps forward after every byte returned, so a controller that keeps acknowledging reads a block of consecutive registers.

When the CRC input is high, every data byte is followed by a CRC byte. For the first data byte of a read phase, the CRC covers every byte on the bus since the first start of the transaction. Each later data byte has a CRC computed over that byte alone. A negative acknowledge from the controller on a CRC byte ends the read, and the target goes back to idle. The register file sits outside the block and is reached through a synchronous read port. The bus pins are open-drain: the block samples SCL and SDA and has one enable that pulls SDA low.

Top module: `i2ctr_read_engine`

## Requirements
- R1: Out of reset the SDA pull-down enable and the read strobe are both low.
- R2: A start condition, repeated or not, begins address reception with SDA released. The first byte carries the 7-bit target address in bits 7:1, MSB first, and the R/W flag in bit 0 (1 = read). When the address equals `TARGET_ADDR`, the target pulls SDA low for the ninth clock.
- R3: When the address does not match, the target gives no acknowledge and leaves SDA released until the next start. Bytes written in that transaction do not change the read pointer.
- R4: After a write-addressed first byte, the target acknowledges the next byte and stores it as the 8-bit read pointer.
- R5: After a repeated start and a read-addressed byte, the target returns the register at the read pointer, MSB first.
- R6: The read pointer survives a stop. A read phase after a stop and a new start, with or without a preceding address write, returns the register at the stored pointer.
- R7: The pointer increments after each returned data byte and wraps from 0xFF to 0x00. Without CRC, an acknowledge on a data byte brings the next register. A negative acknowledge releases the bus until the next start.
- R8: With CRC enabled, a CRC byte follows every data byte, whatever the controller answers to that data byte. The CRC uses polynomial x^8+x^2+x+1 (0x07) with initial value 0, processed MSB first. The first one covers every bus byte since the last stop, or since reset, including address bytes. The CRC restarts at zero after each CRC byte and at each stop.
- R9: An acknowledge on a CRC byte brings the next data byte. A negative acknowledge on it returns the target to idle with SDA released. A stop always releases SDA.
- R10: The target changes SDA only while SCL is low, so SDA is stable throughout each SCL high phase.
- R11: The read strobe is a single-cycle pulse. The register data is taken in the cycle after the strobe.
- R12: Data bytes written after the register address are not acknowledged and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| crc_en | input | 1 | 1 appends a CRC byte after each data byte |
| rd_en | output | 1 | One-cycle register read strobe |
| rd_addr | output | 8 | Register address for the read |
| rd_data | input | 8 | Register data, valid the cycle after `rd_en` |

## Verification
SDA responds about three clock cycles after an SCL falling edge: two synchronizer stages, then the state register. The bench therefore changes its own SDA four cycles into the low phase. It samples the target's SDA four cycles and seven cycles into the high phase, and both samples must agree. Register data is due one cycle after the strobe and is loaded into the shifter at least one SCL phase later, so the bench register model answers on the clock edge after the strobe. CRC values and register contents are computed arithmetically in the bench for every address, length, start style and CRC setting in the sweep.

// File: rtl/i2ctr_pkg.sv
// Shared constants and types of the I2C target read engine.
package i2ctr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    // SCL rise count at which the ninth (handshake) clock begins / ends
    localparam logic [CNT_W-1:0] SLOT_ACK = 4'd8;
    localparam logic [CNT_W-1:0] SLOT_END = 4'd9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_REG,
        S_SEND,
        S_SKIP
    } eng_state_t;

    typedef enum logic {
        K_DATA,
        K_CRC
    } send_kind_t;
endpackage

// File: rtl/i2ctr_bus_sync.sv
// Brings SCL/SDA into the clock domain and derives bus events.
// Assumes STAGES >= 2 and that SCL phases last several clock cycles.
module i2ctr_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Synchronizer chains and one-cycle history; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    // Edge and start/stop decode on the synchronized lines.
    always_comb begin
        scl_s     = scl_p[STAGES-1];
        sda_s     = sda_p[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2ctr_crc8.sv
// Byte-wise CRC-8 accumulator, MSB first. A clear together with an
// update restarts from INIT and folds in the new byte.
module i2ctr_crc8 #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc_q
);
    logic [7:0] nxt;

    // Fold one byte into the running value, one bit per step.
    always_comb begin
        nxt = clr ? INIT : crc_q;
        for (int i = 0; i < 8; i++) begin
            if (nxt[7] ^ din[7-i]) nxt = {nxt[6:0], 1'b0} ^ POLY;
            else                   nxt = {nxt[6:0], 1'b0};
        end
    end

    // Hold the accumulated value.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= INIT;
        else if (upd) crc_q <= nxt;
        else if (clr) crc_q <= INIT;
    end
endmodule

// File: rtl/i2ctr_read_engine.sv
// I2C target serving register reads with optional per-byte CRC.
// Assumes the clock is fast enough that every SCL phase spans at least
// six cycles; SDA is only ever pulled low, never driven high.
module i2ctr_read_engine
    import i2ctr_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h2C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              crc_en,
    output logic              rd_en,
    output logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    eng_state_t        st;
    send_kind_t        kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, ptr, nxt_byte, crc_din, crc_q;
    logic              cap_pend, peer_ack, crc_clr, crc_upd;

    i2ctr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    i2ctr_crc8 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (crc_clr),
        .upd  (crc_upd),
        .din  (crc_din),
        .crc_q(crc_q)
    );

    // Bus protocol sequencer, register pointer and transmit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            kind     <= K_DATA;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            nxt_byte <= '0;
            crc_din  <= '0;
            cap_pend <= 1'b0;
            peer_ack <= 1'b0;
            crc_clr  <= 1'b0;
            crc_upd  <= 1'b0;
            sda_oe   <= 1'b0;
            rd_en    <= 1'b0;
            rd_addr  <= '0;
        end else begin
            rd_en    <= 1'b0;
            crc_upd  <= 1'b0;
            crc_clr  <= 1'b0;
            cap_pend <= rd_en;
            if (cap_pend) nxt_byte <= rd_data;

            if (stop_evt) begin
                st      <= S_IDLE;
                sda_oe  <= 1'b0;
                crc_clr <= 1'b1;
            end else if (start_evt) begin
                st     <= S_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    S_ADDR, S_REG: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt < SLOT_ACK) rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                        end else if (scl_fall && cnt == SLOT_ACK) begin
                            crc_din <= rx_sh;
                            if (st == S_REG) begin
                                ptr     <= rx_sh;
                                sda_oe  <= 1'b1;
                                crc_upd <= 1'b1;
                            end else if (rx_sh[BYTE_W-1:1] == TARGET_ADDR) begin
                                sda_oe  <= 1'b1;
                                crc_upd <= 1'b1;
                                if (rx_sh[0]) begin
                                    rd_en   <= 1'b1;
                                    rd_addr <= ptr;
                                end
                            end else begin
                                st <= S_SKIP;
                            end
                        end else if (scl_fall && cnt == SLOT_END) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            if (st == S_ADDR && rx_sh[0]) begin
                                st      <= S_SEND;
                                kind    <= K_DATA;
                                tx_sh   <= nxt_byte;
                                sda_oe  <= ~nxt_byte[BYTE_W-1];
                                crc_din <= nxt_byte;
                                crc_upd <= 1'b1;
                                ptr     <= ptr + 1'b1;
                                rd_en   <= 1'b1;
                                rd_addr <= ptr + 1'b1;
                            end else if (st == S_ADDR) begin
                                st <= S_REG;
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                    end
                    S_SEND: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == SLOT_ACK) peer_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (cnt < SLOT_ACK) begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[BYTE_W-2];
                            end else if (cnt == SLOT_ACK) begin
                                sda_oe <= 1'b0;
                            end else begin
                                cnt <= '0;
                                if (kind == K_DATA && crc_en) begin
                                    kind    <= K_CRC;
                                    tx_sh   <= crc_q;
                                    sda_oe  <= ~crc_q[BYTE_W-1];
                                    crc_clr <= 1'b1;
                                end else if (peer_ack) begin
                                    kind    <= K_DATA;
                                    tx_sh   <= nxt_byte;
                                    sda_oe  <= ~nxt_byte[BYTE_W-1];
                                    crc_din <= nxt_byte;
                                    crc_upd <= 1'b1;
                                    ptr     <= ptr + 1'b1;
                                    rd_en   <= 1'b1;
                                    rd_addr <= ptr + 1'b1;
                                end else begin
                                    st      <= S_IDLE;
                                    sda_oe  <= 1'b0;
                                    crc_clr <= 1'b1;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2ctr_read_engine_chk.sv
// Protocol checker for the read engine, bound to every instance.
// Assumes SCL low phases outlast the synchronizer delay.
module i2ctr_read_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic rd_en,
    input logic start_evt,
    input logic stop_evt
);
    // R10: the pull-down only engages while SCL is low
    a_r10_pull_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R11: read strobe never lasts two cycles
    a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R9: a stop leaves SDA released
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R2: a start begins address reception with SDA released
    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);
endmodule

bind i2ctr_read_engine i2ctr_read_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .rd_en    (rd_en),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
);

// File: tb/i2ctr_read_engine_bench.sv
module i2ctr_read_engine_bench;
    localparam int         CLK_P = 10;
    localparam int         QTR   = 4;
    localparam logic [6:0] TADDR = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_c = 1'b1;
    logic       sda_c = 1'b1;
    logic       crc_en = 1'b0;
    logic       sda_oe, rd_en;
    logic [7:0] rd_addr, rd_data;
    logic       rd_prev, strobe_long;
    wire        sda_bus = sda_c & ~sda_oe;
    int         tests = 0;
    int         fails = 0;

    always #(CLK_P/2) clk = ~clk;

    i2ctr_read_engine #(.TARGET_ADDR(TADDR)) u_i2ctr_read_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_c),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .crc_en (crc_en),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] regval(logic [7:0] a);
        return (a * 8'd29) ^ 8'hA5 ^ {a[3:0], a[7:4]};
    endfunction

    function automatic logic [7:0] crc8(logic [7:0] c, logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    // register file model: answers on the edge after the strobe (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0; rd_prev <= 1'b0; strobe_long <= 1'b0;
        end else begin
            rd_prev <= rd_en;
            if (rd_en && rd_prev) strobe_long <= 1'b1;
            if (rd_en) rd_data <= regval(rd_addr);
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_c = 1'b1; w(QTR); scl_c = 1'b1; w(2*QTR);
        sda_c = 1'b0; w(2*QTR); scl_c = 1'b0; w(QTR);
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; w(QTR); scl_c = 1'b1; w(2*QTR);
        sda_c = 1'b1; w(2*QTR);
    endtask

    task automatic send_bit(logic b);
        w(QTR); sda_c = b; w(QTR); scl_c = 1'b1; w(2*QTR); scl_c = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        logic s0;
        sda_c = 1'b1; w(2*QTR); scl_c = 1'b1; w(QTR);
        s0 = sda_bus; w(QTR-1); b = sda_bus;
        chk("R10", {7'd0, b}, {7'd0, s0});
        w(1); scl_c = 1'b0;
    endtask

    task automatic write_byte(logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nack);
    endtask

    // full transaction: pointer write, then read phase of n bytes
    task automatic do_txn(logic [7:0] rg, int n, logic rs, logic ce, logic rel);
        logic ack;
        logic [7:0] c, d, cb;
        crc_en = ce;
        bus_start();
        write_byte({TADDR, 1'b0}, ack); chk("R2", {7'd0, ack}, 8'd1);
        write_byte(rg, ack);            chk("R4", {7'd0, ack}, 8'd1);
        c = crc8(crc8(8'h00, {TADDR, 1'b0}), rg);
        if (!rs) begin bus_stop(); w(8); c = 8'h00; end
        bus_start();
        write_byte({TADDR, 1'b1}, ack); chk("R2", {7'd0, ack}, 8'd1);
        c = crc8(c, {TADDR, 1'b1});
        for (int k = 0; k < n; k++) begin
            read_byte(d, ce ? 1'b0 : (k == n-1));
            if (k > 0)   chk("R7", d, regval(rg + 8'(k)));
            else if (rs) chk("R5", d, regval(rg));
            else         chk("R6", d, regval(rg));
            if (ce) begin
                c = crc8(c, d);
                read_byte(cb, k == n-1);
                chk("R8", cb, c);
                c = 8'h00;
            end
        end
        if (rel) begin
            read_byte(d, 1'b1);
            if (ce) chk("R9", d, 8'hFF);
            else    chk("R7", d, 8'hFF);
        end
        bus_stop(); w(8);
    endtask

    // read phase only, relying on the stored pointer
    task automatic read_next(logic [7:0] exp_ptr, string tag);
        logic ack;
        logic [7:0] d, cb;
        bus_start();
        write_byte({TADDR, 1'b1}, ack); chk("R2", {7'd0, ack}, 8'd1);
        read_byte(d, ~crc_en);
        chk(tag, d, regval(exp_ptr));
        if (crc_en) begin
            read_byte(cb, 1'b1);
            chk("R8", cb, crc8(crc8(8'h00, {TADDR, 1'b1}), d));
        end
        bus_stop(); w(8);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        w(5);
        chk("R1", {7'd0, sda_oe}, 8'd0);
        chk("R1", {7'd0, rd_en}, 8'd0);
        rst_n = 1'b1; w(5);

        // foreign address: read and write both ignored
        bus_start();
        write_byte({TADDR ^ 7'h01, 1'b1}, ack); chk("R3", {7'd0, ack}, 8'd0);
        read_byte(d, 1'b1);                      chk("R3", d, 8'hFF);
        bus_stop(); w(8);
        bus_start();
        write_byte({TADDR ^ 7'h10, 1'b0}, ack); chk("R3", {7'd0, ack}, 8'd0);
        write_byte(8'h33, ack);                  chk("R3", {7'd0, ack}, 8'd0);
        bus_stop(); w(8);
        read_next(8'h00, "R3");

        // sweep: CRC setting x start style x pointer x length
        for (int ce = 0; ce < 2; ce++)
            for (int rs = 0; rs < 2; rs++)
                for (int k = 0; k < 5; k++) begin
                    logic [7:0] rg = 8'(k * 53 + 7);
                    do_txn(rg, k % 3 + 1, rs[0], ce[0], k == 4);
                    read_next(rg + 8'(k % 3 + 1), "R6");
                end

        // pointer wrap with CRC on each byte
        do_txn(8'hFE, 3, 1'b1, 1'b1, 1'b1);
        read_next(8'h01, "R7");

        // extra write data is refused and keeps the pointer
        crc_en = 1'b0;
        bus_start();
        write_byte({TADDR, 1'b0}, ack); chk("R2", {7'd0, ack}, 8'd1);
        write_byte(8'h40, ack);         chk("R4", {7'd0, ack}, 8'd1);
        write_byte(8'h99, ack);         chk("R12", {7'd0, ack}, 8'd0);
        bus_stop(); w(8);
        read_next(8'h40, "R12");

        chk("R11", {7'd0, strobe_long}, 8'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule